// File: doc/BRIEF.md
# Parallel Key Search Reducer

This block tells whether a search key occurs anywhere in a small array of words. On a start pulse it captures the key and the whole array. In the next cycle the same key is given to every compare lane, and each lane holds a different array element. Each lane raises a one-bit hit flag when its element equals the key. The hit flags are then reduced to one found bit.

A build parameter selects how the flags are reduced. In wired mode all flags are ORed in one step, so the result time does not depend on the number of lanes. In tree mode a register of flags is folded pairwise once per cycle. The same OR stage runs again on its own output, and the number of live flags halves each round until one flag is left after log2(lanes) rounds. `busy` covers the whole search, `done` marks the result with a one-cycle pulse, and `found` keeps the answer until the next search is accepted.

Top module: `par_key_search`

## Requirements
- R1: After reset, `busy`, `done` and `found` are all 0.
- R2: A `start` sampled high while `busy` is 0 captures `key` and `array_in`, and `busy` is 1 from the next cycle on.
- R3: Element i of the array is `array_in[i*WORD_W +: WORD_W]`. `found` is 1 with `done` when at least one element equals the captured key, whatever its position and however many elements match.
- R4: `found` is 0 with `done` when no element equals the captured key.
- R5: In tree mode (`TREE_MODE`=1), `done` rises log2(LANES)+1 clock edges after the edge that accepted `start`. For 8 lanes this is 4 edges: one compare round and three fold rounds.
- R6: In wired mode (`TREE_MODE`=0), `done` rises 2 edges after the accepting edge: one compare round and one single-step OR round.
- R7: `done` is high for exactly one cycle, and `busy` is 0 in that cycle.
- R8: A `start` sampled while `busy` is 1 has no effect. The search in flight keeps its key, its result and its timing, and no extra `done` follows.
- R9: `found` holds its value from `done` until the next accepted `start`, which clears it to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Requests a search; accepted only while idle |
| key | input | WORD_W | Value to search for |
| array_in | input | LANES*WORD_W | Flattened array, element i at bits i*WORD_W upward |
| busy | output | 1 | A search is in progress |
| done | output | 1 | One-cycle pulse when `found` is valid |
| found | output | 1 | 1 when the key was present in the array |

## Verification
The bench runs a tree-mode instance and a wired-mode instance side by side on the same stimulus. The key is placed at lane 0, at the last lane and at a middle lane. A lane that drops out of the fold early, or a fold pair that is mis-indexed, fails only for some of these positions. An array with no match shows whether `found` is set falsely. Arrays with several matches, and an array where every lane matches, show whether the OR merge loses or double-counts hits. A second start with a different key is issued during a search. It shows whether a busy start is ignored, and the exact `done` latency tells the two reduction modes apart.

// File: rtl/par_key_search.sv
module par_key_search #(
  parameter int LANES     = 8,
  parameter int WORD_W    = 8,
  parameter bit TREE_MODE = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [WORD_W-1:0]       key,
  input  logic [LANES*WORD_W-1:0] array_in,
  output logic                    busy,
  output logic                    done,
  output logic                    found
);
  localparam int STEPS   = $clog2(LANES);
  localparam int STEP_W  = $clog2(STEPS + 1);
  localparam int LATENCY = TREE_MODE ? STEPS + 1 : 2;

  typedef enum logic [1:0] {S_IDLE, S_CMP, S_FOLD} state_t;

  state_t                  state;
  logic [WORD_W-1:0]       key_q;
  logic [LANES*WORD_W-1:0] arr_q;
  logic [LANES-1:0]        flags, hit, fold;
  logic [STEP_W-1:0]       step;
  logic                    done_q, found_q;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign hit[i] = (arr_q[i*WORD_W +: WORD_W] == key_q);
    if (i < LANES / 2) begin : g_pair
      assign fold[i] = flags[2*i] | flags[2*i+1];
    end else begin : g_idle
      assign fold[i] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      key_q   <= '0;
      arr_q   <= '0;
      flags   <= '0;
      step    <= '0;
      done_q  <= 1'b0;
      found_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          key_q   <= key;
          arr_q   <= array_in;
          found_q <= 1'b0;
          state   <= S_CMP;
        end
        S_CMP: begin
          flags <= hit;
          step  <= '0;
          state <= S_FOLD;
        end
        S_FOLD: begin
          if (TREE_MODE) begin
            flags <= fold;
            if (step == STEP_W'(STEPS - 1)) begin
              found_q <= fold[0];
              done_q  <= 1'b1;
              state   <= S_IDLE;
            end else begin
              step <= step + 1'b1;
            end
          end else begin
            found_q <= |flags;
            done_q  <= 1'b1;
            state   <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy  = (state != S_IDLE);
  assign done  = done_q;
  assign found = found_q;
endmodule

// File: rtl/par_key_search_chk.sv
module par_key_search_chk #(
  parameter int LAT = 4
) (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic done,
  input logic found
);
  logic [7:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (start && !busy) cnt <= '0;
    else if (busy)           cnt <= cnt + 8'd1;
  end

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r7_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r2_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  // R5 and R6 by mode; R8: a busy start must not restart the count
  a_r5_latency: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (cnt == 8'(LAT)));

  a_r9_found_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(found) |-> (done || $past(start && !busy)));

  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!done && !found));
endmodule

bind par_key_search par_key_search_chk #(.LAT(LATENCY)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start),
  .busy(busy), .done(done), .found(found)
);

// File: tb/test_par_key_search.sv
module test_par_key_search;
  localparam int CLK_PERIOD = 10;
  localparam int LANES  = 8;
  localparam int WORD_W = 8;
  localparam int LAT_T  = $clog2(LANES) + 1;
  localparam int LAT_W  = 2;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [WORD_W-1:0] key = '0;
  logic [LANES*WORD_W-1:0] array_in = '0;
  logic busy_t, done_t, found_t, busy_w, done_w, found_w;
  int vectors = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  par_key_search #(.LANES(LANES), .WORD_W(WORD_W), .TREE_MODE(1'b1)) i_par_key_search (
    .clk(clk), .rst_n(rst_n), .start(start), .key(key), .array_in(array_in),
    .busy(busy_t), .done(done_t), .found(found_t));

  par_key_search #(.LANES(LANES), .WORD_W(WORD_W), .TREE_MODE(1'b0)) i_par_key_search_w (
    .clk(clk), .rst_n(rst_n), .start(start), .key(key), .array_in(array_in),
    .busy(busy_w), .done(done_w), .found(found_w));

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic ref_found(input logic [WORD_W-1:0] k,
                                     input logic [LANES*WORD_W-1:0] a);
    logic r = 1'b0;
    for (int i = 0; i < LANES; i++) if (a[i*WORD_W +: WORD_W] == k) r = 1'b1;
    return r;
  endfunction

  // one search; optional busy start with another key at observed cycle 1
  task automatic search(input string req, input logic [WORD_W-1:0] k,
                        input logic [LANES*WORD_W-1:0] a, input bit poke);
    int lt = -1, lw = -1, ndone_t = 0, ndone_w = 0;
    logic ft = 1'b0, fw = 1'b0;
    logic exp = ref_found(k, a);
    @(negedge clk);
    key = k; array_in = a; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check({req, " R2 busy after start (tree)"}, busy_t, 1);
    check({req, " R2 busy after start (wired)"}, busy_w, 1);
    if (poke) begin
      key = ~k; array_in = ~a; start = 1'b1;
    end
    for (int c = 1; c <= 10; c++) begin
      @(negedge clk);
      start = 1'b0;
      if (done_t) begin
        ndone_t++;
        if (lt < 0) begin
          lt = c;
          ft = found_t;
          check({req, " R7 busy low at done (tree)"}, busy_t, 0);
        end
      end
      if (done_w) begin
        ndone_w++;
        if (lw < 0) begin
          lw = c;
          fw = found_w;
          check({req, " R7 busy low at done (wired)"}, busy_w, 0);
        end
      end
    end
    check({req, " R5 tree latency"}, lt, LAT_T);
    check({req, " R6 wired latency"}, lw, LAT_W);
    check({req, " R3/R4 found (tree)"}, ft, exp);
    check({req, " R3/R4 found (wired)"}, fw, exp);
    check({req, " R7/R8 single done (tree)"}, ndone_t, 1);
    check({req, " R7/R8 single done (wired)"}, ndone_w, 1);
    check({req, " R9 found held (tree)"}, found_t, exp);
    check({req, " R9 found held (wired)"}, found_w, exp);
  endtask

  function automatic logic [LANES*WORD_W-1:0] fill(input logic [WORD_W-1:0] base);
    logic [LANES*WORD_W-1:0] a;
    for (int i = 0; i < LANES; i++) a[i*WORD_W +: WORD_W] = base + WORD_W'(i);
    return a;
  endfunction

  task automatic t_reset();
    @(negedge clk);
    check("R1 busy (tree)", busy_t, 0);
    check("R1 done (tree)", done_t, 0);
    check("R1 found (tree)", found_t, 0);
    check("R1 busy (wired)", busy_w, 0);
    check("R1 found (wired)", found_w, 0);
  endtask

  task automatic t_positions();
    search("R3 lane0", 8'h10, fill(8'h10), 1'b0);
    search("R3 lane7", 8'h17, fill(8'h10), 1'b0);
    search("R3 lane5", 8'h15, fill(8'h10), 1'b0);
  endtask

  task automatic t_miss();
    search("R4 miss", 8'h42, fill(8'h10), 1'b0);
  endtask

  task automatic t_multi();
    logic [LANES*WORD_W-1:0] a = fill(8'h20);
    a[2*WORD_W +: WORD_W] = 8'h99;
    a[6*WORD_W +: WORD_W] = 8'h99;
    search("R3 two hits", 8'h99, a, 1'b0);
    search("R3 all hit", 8'h55, {LANES{8'h55}}, 1'b0);
  endtask

  task automatic t_busy_start();
    search("R8 busy start ignored miss", 8'h01, fill(8'h30), 1'b1);
    search("R8 busy start ignored hit", 8'h33, fill(8'h30), 1'b1);
  endtask

  task automatic t_clear();
    search("R9 prime", 8'h11, fill(8'h10), 1'b0);
    @(negedge clk);
    key = 8'hEE; array_in = fill(8'h00); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R9 cleared by start (tree)", found_t, 0);
    check("R9 cleared by start (wired)", found_w, 0);
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_positions();
    t_miss();
    t_multi();
    t_busy_start();
    t_clear();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule